// File: doc/BRIEF.md
# Page Write Collector with Deselect Commit

This block sits between a serial memory's command decoder and its storage array. Once the decoder has accepted a page-program command and its start address, it passes each incoming serial data bit to this block. The bits are packed into bytes MSB first. Each completed byte is stored in a page latch at an offset that starts at the low address bits and counts up, wrapping inside the page. A byte mask records which offsets were received.

When the decoder reports that the device has been deselected, the block checks three conditions: the deselect came on an exact byte boundary, at least one full byte was received, and the protection logic allows the write. If all three hold, the block enters a self-timed program cycle of `WR_CYCLES` system clocks. Otherwise it drops the collected data.

During the program cycle the busy flag stays high, and select changes and new commands are ignored. In the last busy cycle the block presents the page number, page data and byte mask to the array with a one-cycle write strobe. In that same cycle it pulses a request to clear the write-enable latch.

The controller uses four states:

| State | Role |
|---|---|
| `PW_IDLE` | Waiting for a command. |
| `PW_FILL` | Collecting data bits. |
| `PW_PROG` | Timed busy period. |
| `PW_COMMIT` | One cycle in which the array is strobed. |

The transitions are:

- **Start:** IDLE→FILL on a command start while selected.
- **Commit:** FILL→PROG on deselect when the deselect is valid.
- **Discard:** FILL→IDLE on any other deselect.
- **Time-up:** PROG→COMMIT when the cycle counter reaches its last value.
- **Done:** COMMIT→IDLE.

Top module: `pw_page_writer`

## Requirements
- R1: After reset, `wip`, `arr_we` and `wel_clr` are all 0.
- R2: Data bits are taken MSB first. The k-th byte received (k from 0) is placed at page offset (start_addr[4:0] + k) mod 32, and appears on `arr_data[8*off+7:8*off]`. `arr_page` equals start_addr[ADDR_W-1:5].
- R3: When more than 32 bytes are sent, the offset wraps to 0 and overwrites earlier bytes. The most recent byte for each offset is the one written.
- R4: `arr_mask` bit i is 1 exactly when offset i received a byte in this command. Unmasked offsets are left untouched in the array.
- R5: A deselect that arrives after a partial byte (1 to 7 bits since the last full byte) discards the command. In that case `wip`, `arr_we` and `wel_clr` stay 0.
- R6: A command with zero complete data bytes commits nothing and does not pulse `wel_clr`.
- R7: After a valid deselect, `wip` is 1 for exactly `WR_CYCLES` consecutive cycles, starting with the cycle after the deselect is seen. `arr_we` is 1 only in the last of those cycles.
- R8: Changes on `cs_n` during the busy period neither shorten nor extend it.
- R9: `wel_clr` pulses for one cycle, together with `arr_we`, once for each committed write.
- R10: While `wip` is 1, a command start, data bits and a following deselect are all ignored. No second write results from them.
- R11: If `wr_allow` is 0 when the deselect is seen, the command is discarded and `wip` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Synchronised chip select, low = selected |
| wr_begin | input | 1 | Pulse: page-program command and address accepted |
| start_addr | input | ADDR_W | Byte address of the first data byte |
| bit_tick | input | 1 | Pulse: one serial data bit is valid |
| bit_val | input | 1 | Value of that data bit |
| wr_allow | input | 1 | Write permission from the protection logic |
| wip | output | 1 | Program cycle in progress |
| wel_clr | output | 1 | Request to clear the write-enable latch |
| arr_we | output | 1 | One-cycle write strobe to the array |
| arr_page | output | ADDR_W-5 | Page number being written |
| arr_data | output | PAGE_BYTES*8 | Page latch contents, offset 0 in the low byte |
| arr_mask | output | PAGE_BYTES | Per-byte write enables |

## Verification
The bench sweeps every start offset with varied byte counts, which separates offset arithmetic from plain sequential placement. It then sends 25 to 40 bytes from a late offset, which exercises wrap-around and last-writer-wins against stale bytes. Deselects after 1 to 7 stray bits, deselects with zero bytes, and deselects with permission withheld each tell a clean boundary apart from a near miss. Toggling select, or issuing a whole new command during the busy period, shows that the timer and the commit are independent of the pins until the cycle ends.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [1:0] {
        PW_IDLE,
        PW_FILL,
        PW_PROG,
        PW_COMMIT
    } pw_state_e;

endpackage

// File: rtl/pw_bit_assembler.sv
module pw_bit_assembler (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       enable,
    input  logic       bit_tick,
    input  logic       bit_val,
    output logic       byte_rdy,
    output logic [7:0] byte_out,
    output logic       at_boundary
);

    logic [2:0] bit_cnt_q;
    logic [6:0] shift_q;
    logic       take;

    assign take        = enable && bit_tick;
    assign byte_rdy    = take && (bit_cnt_q == 3'd7);
    assign byte_out    = {shift_q, bit_val};
    assign at_boundary = (bit_cnt_q == 3'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
        end else if (clear) begin
            bit_cnt_q <= '0;
        end else if (take) begin
            bit_cnt_q <= bit_cnt_q + 3'd1;
            shift_q   <= {shift_q[5:0], bit_val};
        end
    end

endmodule

// File: rtl/pw_page_latch.sv
module pw_page_latch #(
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic [OFF_W-1:0]        start_off,
    input  logic                    wr_en,
    input  logic [7:0]              byte_in,
    output logic [PAGE_BYTES*8-1:0] data_flat,
    output logic [PAGE_BYTES-1:0]   mask,
    output logic                    any_byte
);

    logic [OFF_W-1:0] ptr_q;
    logic [7:0]       data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (clear) begin
            ptr_q <= start_off;
        end else if (wr_en) begin
            ptr_q <= ptr_q + OFF_W'(1);
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[g] <= '0;
                mask_q[g] <= 1'b0;
            end else if (clear) begin
                mask_q[g] <= 1'b0;
            end else if (wr_en && (ptr_q == OFF_W'(g))) begin
                data_q[g] <= byte_in;
                mask_q[g] <= 1'b1;
            end
        end
        assign data_flat[8*g +: 8] = data_q[g];
    end

    assign mask     = mask_q;
    assign any_byte = |mask_q;

endmodule

// File: rtl/pw_write_fsm.sv
module pw_write_fsm
    import pw_pkg::*;
#(
    parameter int WR_CYCLES = 625000,
    localparam int CNT_W    = $clog2(WR_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_begin,
    input  logic at_boundary,
    input  logic any_byte,
    input  logic wr_allow,
    output logic load,
    output logic collect,
    output logic wip,
    output logic arr_we,
    output logic wel_clr
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 2);

    pw_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PW_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == PW_PROG) ? cnt_q + CNT_W'(1) : '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE: begin
                if (wr_begin && !cs_n) state_d = PW_FILL;
            end
            PW_FILL: begin
                if (cs_n) begin
                    if (at_boundary && any_byte && wr_allow) state_d = PW_PROG;
                    else                                     state_d = PW_IDLE;
                end
            end
            PW_PROG: begin
                if (cnt_q == LAST) state_d = PW_COMMIT;
            end
            PW_COMMIT: begin
                state_d = PW_IDLE;
            end
            default: state_d = PW_IDLE;
        endcase
    end

    always_comb begin
        load    = (state_q == PW_IDLE) && wr_begin && !cs_n;
        collect = (state_q == PW_FILL) && !cs_n;
        wip     = (state_q == PW_PROG) || (state_q == PW_COMMIT);
        arr_we  = (state_q == PW_COMMIT);
        wel_clr = (state_q == PW_COMMIT);
    end

endmodule

// File: rtl/pw_page_writer.sv
module pw_page_writer #(
    parameter int ADDR_W     = 13,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 625000,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    wr_begin,
    input  logic [ADDR_W-1:0]       start_addr,
    input  logic                    bit_tick,
    input  logic                    bit_val,
    input  logic                    wr_allow,
    output logic                    wip,
    output logic                    wel_clr,
    output logic                    arr_we,
    output logic [PAGE_W-1:0]       arr_page,
    output logic [PAGE_BYTES*8-1:0] arr_data,
    output logic [PAGE_BYTES-1:0]   arr_mask
);

    logic       load, collect;
    logic       byte_rdy, at_boundary, any_byte;
    logic [7:0] byte_val;
    logic [PAGE_W-1:0] page_q;

    pw_write_fsm #(.WR_CYCLES(WR_CYCLES)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .wr_begin    (wr_begin),
        .at_boundary (at_boundary),
        .any_byte    (any_byte),
        .wr_allow    (wr_allow),
        .load        (load),
        .collect     (collect),
        .wip         (wip),
        .arr_we      (arr_we),
        .wel_clr     (wel_clr)
    );

    pw_bit_assembler i_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (load),
        .enable      (collect),
        .bit_tick    (bit_tick),
        .bit_val     (bit_val),
        .byte_rdy    (byte_rdy),
        .byte_out    (byte_val),
        .at_boundary (at_boundary)
    );

    pw_page_latch #(.PAGE_BYTES(PAGE_BYTES)) i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (load),
        .start_off (start_addr[OFF_W-1:0]),
        .wr_en     (byte_rdy),
        .byte_in   (byte_val),
        .data_flat (arr_data),
        .mask      (arr_mask),
        .any_byte  (any_byte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)    page_q <= '0;
        else if (load) page_q <= start_addr[ADDR_W-1:OFF_W];
    end

    assign arr_page = page_q;

endmodule

// File: rtl/pw_page_writer_chk.sv
module pw_page_writer_chk #(
    parameter int PAGE_BYTES = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_n,
    input logic                  wip,
    input logic                  arr_we,
    input logic                  wel_clr,
    input logic [PAGE_BYTES-1:0] arr_mask
);

    AST_WE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> wip); // R7

    AST_BUSY_ENDS_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !wip); // R7

    AST_BUSY_FALL_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> $past(arr_we)); // R7

    AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && !arr_we) |=> wip); // R8

    AST_START_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(cs_n)); // R5

    AST_MASK_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_mask != '0)); // R6

    AST_WEL_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> arr_we); // R9

    AST_WEL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !wel_clr); // R9

endmodule

bind pw_page_writer pw_page_writer_chk #(.PAGE_BYTES(PAGE_BYTES)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .wip      (wip),
    .arr_we   (arr_we),
    .wel_clr  (wel_clr),
    .arr_mask (arr_mask)
);

// File: tb/test_pw_page_writer.sv
module test_pw_page_writer;

    localparam int ADDR_W     = 13;
    localparam int PAGE_BYTES = 32;
    localparam int WR_CYCLES  = 24;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                    rst_n = 1'b0;
    logic                    cs_n = 1'b1;
    logic                    wr_begin = 1'b0;
    logic [ADDR_W-1:0]       start_addr = '0;
    logic                    bit_tick = 1'b0;
    logic                    bit_val = 1'b0;
    logic                    wr_allow = 1'b1;
    logic                    wip, wel_clr, arr_we;
    logic [ADDR_W-6:0]       arr_page;
    logic [PAGE_BYTES*8-1:0] arr_data;
    logic [PAGE_BYTES-1:0]   arr_mask;

    pw_page_writer #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES))
    i_pw_page_writer (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_begin(wr_begin),
        .start_addr(start_addr), .bit_tick(bit_tick), .bit_val(bit_val),
        .wr_allow(wr_allow), .wip(wip), .wel_clr(wel_clr), .arr_we(arr_we),
        .arr_page(arr_page), .arr_data(arr_data), .arr_mask(arr_mask)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;
    logic [7:0]            exp_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] exp_mask;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [7:0] byte_of(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 5) & 255);
    endfunction

    task automatic start_write(input logic [ADDR_W-1:0] a);
        cs_n = 1'b0; wr_begin = 1'b1; start_addr = a;
        step();
        wr_begin = 1'b0;
        exp_mask = '0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int k = 7; k > 7 - nbits; k--) begin
            bit_tick = 1'b1; bit_val = b[k];
            step();
        end
        bit_tick = 1'b0;
    endtask

    task automatic observe(input bit commit, input logic [ADDR_W-1:0] a,
                           input bit toggle, input string req);
        int wip_n = 0, we_n = 0, we_at = -1, wel_n = 0;
        bit first_wip = 0;
        cs_n = 1'b1;
        for (int c = 0; c < WR_CYCLES + 4; c++) begin
            step();
            if (c == 0) first_wip = wip;
            if (wip) wip_n++;
            if (wel_clr) wel_n++;
            if (arr_we) begin
                we_n++; we_at = c;
                chk(arr_page == a[ADDR_W-1:5], "R2", "page", arr_page, a[ADDR_W-1:5]);
                chk(arr_mask == exp_mask, "R4", "mask", arr_mask, exp_mask);
                for (int i = 0; i < PAGE_BYTES; i++)
                    if (exp_mask[i])
                        chk(arr_data[8*i +: 8] == exp_data[i], req, "data byte",
                            arr_data[8*i +: 8], exp_data[i]);
            end
            if (toggle) cs_n = c[0];
        end
        cs_n = 1'b1;
        chk(first_wip == commit, req, "wip after deselect", first_wip, commit);
        chk(wip_n == (commit ? WR_CYCLES : 0), "R7", "wip length", wip_n, commit ? WR_CYCLES : 0);
        chk(we_n == (commit ? 1 : 0), req, "strobe count", we_n, commit ? 1 : 0);
        if (commit)
            chk(we_at == WR_CYCLES - 1, "R7", "strobe position", we_at, WR_CYCLES - 1);
        chk(wel_n == (commit ? 1 : 0), "R9", "wel_clr count", wel_n, commit ? 1 : 0);
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input int nbytes, input int extra,
                            input bit allow, input int seed, input bit toggle, input string req);
        int off;
        start_write(a);
        wr_allow = allow;
        for (int i = 0; i < nbytes; i++) begin
            off = (int'(a[4:0]) + i) % PAGE_BYTES;
            exp_data[off] = byte_of(seed, i);
            exp_mask[off] = 1'b1;
            send_bits(byte_of(seed, i), 8);
        end
        if (extra > 0) send_bits(byte_of(seed, 99), extra);
        observe(nbytes > 0 && extra == 0 && allow, a, toggle, req);
        wr_allow = 1'b1;
    endtask

    initial begin
        repeat (3) step();
        chk(wip == 1'b0, "R1", "wip in reset", wip, 0);
        chk(arr_we == 1'b0, "R1", "arr_we in reset", arr_we, 0);
        chk(wel_clr == 1'b0, "R1", "wel_clr in reset", wel_clr, 0);
        rst_n = 1'b1;
        step();
        chk(wip == 1'b0, "R1", "wip after reset", wip, 0);

        // R2: every start offset, varied byte counts
        for (int off = 0; off < PAGE_BYTES; off++)
            do_write(ADDR_W'(((off * 3) << 5) | off), 1 + (off * 5) % 8, 0, 1'b1, off, 1'b0, "R2");
        // R4: single byte at the last offset
        do_write(ADDR_W'(13'h1FFF), 1, 0, 1'b1, 7, 1'b0, "R4");
        // R3: overfill from a late offset
        for (int n = 25; n <= 40; n += 3)
            do_write(ADDR_W'((9 << 5) | 20), n, 0, 1'b1, n, 1'b0, "R3");
        // R5: stray bits after full bytes
        for (int e = 1; e < 8; e++)
            do_write(ADDR_W'(13'h0404), 2, e, 1'b1, e, 1'b0, "R5");
        // R6: no complete byte
        do_write(ADDR_W'(13'h0100), 0, 0, 1'b1, 1, 1'b0, "R6");
        do_write(ADDR_W'(13'h0100), 0, 3, 1'b1, 2, 1'b0, "R6");
        // R11: permission withheld
        do_write(ADDR_W'(13'h0222), 4, 0, 1'b0, 3, 1'b0, "R11");
        // R8: select toggling during the busy period
        do_write(ADDR_W'(13'h0333), 3, 0, 1'b1, 4, 1'b1, "R8");

        // R10: a complete new command during the busy period is ignored
        start_write(ADDR_W'(13'h0040));
        send_bits(8'hA5, 8);
        send_bits(8'h3C, 8);
        cs_n = 1'b1;
        step();
        chk(wip == 1'b1, "R10", "busy after commit", wip, 1);
        start_write(ADDR_W'(13'h0080));
        send_bits(8'h77, 8);
        cs_n = 1'b1;
        step();
        chk(wip == 1'b1, "R10", "still busy", wip, 1);
        for (int c = 0; c < WR_CYCLES + 4 && wip; c++) step();
        chk(wip == 1'b0, "R10", "busy ended", wip, 0);
        begin
            int stray = 0;
            for (int c = 0; c < WR_CYCLES + 4; c++) begin
                step();
                if (wip || arr_we) stray++;
            end
            chk(stray == 0, "R10", "second write cycles", stray, 0);
        end

        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule